// File: doc/BRIEF.md
# One-Time Configuration Fuse Commit Controller

This block keeps a small one-time-programmable configuration store for a secure-boot setup. While the part is still in its factory phase, a privileged management controller places configuration bytes into a staging mirror. The fuse array stays blank during this phase, and the secure-boot state reads as undefined: neither enabled nor disabled. When the controller issues the commit command, the block copies the mirror into the fuses one byte per clock cycle. It then seals the array for good, tightens the flash-region access permissions and asks for a system reset.

The store is 256 bytes by default. Bytes 0 to 31 hold the digest of the root public key, and byte 32 holds the boot profile. Bit 0 of the profile byte is the verified-boot enable, which the block decodes into its secure-boot state output. A behavioural register model stands in for the physical fuses. Each fuse byte can be written only once. Input `rst` is the power-on initialisation of that model. The `reset_req` output goes to the system and is not looped back.

Top module: `otp_commit_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, the outputs are as follows: `stat_unprog`=1, `stat_prog`=0, `stat_mfg_open`=1, `busy`=0, `err_locked`=0, `reset_req`=0, `acc_lockdown`=0, `sb_state`=0.
- R2: Every request with `req_priv`=0 is answered one cycle later with `rsp_valid`=1, `rsp_refused`=1 and `rsp_rdata`=0. It has no effect on the mirror, the fuses or the status outputs.
- R3: Op codes are 0 stage, 1 read fuse, 2 commit and 3 read mirror. A privileged stage (op 0) before sealing writes `req_wdata` to mirror byte `req_addr`. A later read mirror (op 3) returns that byte on `rsp_rdata` in the cycle after the request.
- R4: Before sealing, a privileged read fuse (op 1) returns `rsp_rdata`=0 with `rsp_not_prog`=1.
- R5: A privileged commit (op 2) on an unsealed part raises `busy` in the cycle after the request. `busy` stays high for exactly FUSE_BYTES cycles, during which mirror byte i is burned into fuse byte i.
- R6: In the cycle where `busy` falls, `stat_prog` becomes 1, `stat_unprog` and `stat_mfg_open` become 0, and `acc_lockdown` becomes 1. In that same cycle `reset_req` is high, and it is high for that one cycle only.
- R7: After sealing, read fuse returns the committed byte with `rsp_not_prog`=0. A later stage request changes neither the fuses nor the mirror.
- R8: A commit request after sealing is ignored: `busy` stays 0, no `reset_req` is issued and the fuses keep their values. It sets `err_locked`, which stays high until `rst`.
- R9: Any request that arrives while `busy` is high is refused (`rsp_refused`=1) and has no effect.
- R10: `sb_state` is 0 (undefined) while the part is unsealed. Once sealed, it is 2 (enabled) when bit 0 of fuse byte 32 is 1, and 1 (disabled) when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on initialisation |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_priv | input | 1 | Request comes from the privileged management controller |
| req_op | input | 2 | 0 stage, 1 read fuse, 2 commit, 3 read mirror |
| req_addr | input | AW | Byte address |
| req_wdata | input | 8 | Stage data |
| rsp_valid | output | 1 | Response strobe, one cycle after each request |
| rsp_refused | output | 1 | Request was refused |
| rsp_not_prog | output | 1 | Fuse read on an unprogrammed array |
| rsp_rdata | output | 8 | Read data |
| busy | output | 1 | Burn in progress |
| stat_unprog | output | 1 | Fuses not programmed |
| stat_prog | output | 1 | Fuses programmed and sealed |
| stat_mfg_open | output | 1 | Manufacturing phase still open |
| err_locked | output | 1 | Sticky: commit attempted after sealing |
| acc_lockdown | output | 1 | Region access permissions tightened |
| reset_req | output | 1 | One-cycle system reset request |
| sb_state | output | 2 | Secure-boot state: 0 undefined, 1 disabled, 2 enabled |

## Verification
The whole mirror is filled with pseudo-random bytes from a fixed seed, and unprivileged writes carrying inverted data are scattered among the stage requests. A full mirror read-back then shows whether a refused request leaked into storage. Reading every fuse byte after the burn tells a correct byte-by-byte copy apart from an off-by-one address or a missed last byte. Counting the `busy` cycles separates a correct burn length from one that is short or long by a cycle. The run is repeated with the profile enable bit forced to 1 and then to 0, which separates the enabled and disabled decodes. After sealing, a second stage request and a second commit are issued, showing that sealed contents are frozen and that the error flag is set.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int BYTE_W         = 8;
    localparam int DIGEST_BYTES   = 32;
    localparam int PROFILE_OFFSET = DIGEST_BYTES;

    typedef enum logic [1:0] {
        OP_STAGE       = 2'd0,
        OP_READ_FUSE   = 2'd1,
        OP_COMMIT      = 2'd2,
        OP_READ_MIRROR = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SB_UNDEF    = 2'd0,
        SB_DISABLED = 2'd1,
        SB_ENABLED  = 2'd2
    } sb_state_e;

    typedef enum logic [1:0] {
        SEQ_OPEN,
        SEQ_BURN,
        SEQ_SEALED
    } seq_e;

    typedef struct packed {
        logic              valid;
        logic              refused;
        logic              not_prog;
        logic [BYTE_W-1:0] data;
    } rsp_t;

    function automatic sb_state_e decode_profile(input logic sealed, input logic verify_en);
        if (!sealed)
            return SB_UNDEF;
        return verify_en ? SB_ENABLED : SB_DISABLED;
    endfunction

endpackage

// File: rtl/otp_mirror.sv
module otp_mirror
    import otp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     host_addr,
    output logic [BYTE_W-1:0] host_data,
    input  logic [AW-1:0]     burn_addr,
    output logic [BYTE_W-1:0] burn_data
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign host_data = mem[host_addr];
    assign burn_data = mem[burn_addr];

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
    import otp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [AW-1:0]     prog_addr,
    input  logic [BYTE_W-1:0] prog_data,
    input  logic              seal,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              verify_en
);

    logic [BYTE_W-1:0] cell_q [DEPTH];

    // Each byte cell accepts one write in its lifetime and none once sealed.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [BYTE_W-1:0] val_q;
        logic              burnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                val_q   <= '0;
                burnt_q <= 1'b0;
            end else if (prog_en && !seal && !burnt_q && prog_addr == AW'(g)) begin
                val_q   <= prog_data;
                burnt_q <= 1'b1;
            end
        end

        assign cell_q[g] = val_q;
    end

    assign rd_data   = cell_q[rd_addr];
    assign verify_en = cell_q[PROFILE_OFFSET][0];

endmodule

// File: rtl/otp_commit_seq.sv
module otp_commit_seq
    import otp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_cmd,
    output logic          busy,
    output logic          sealed,
    output logic          burn_en,
    output logic [AW-1:0] burn_addr,
    output logic          reset_pulse,
    output logic          late_commit
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    seq_e          st_q;
    logic [AW-1:0] idx_q;
    logic          pulse_q;
    logic          err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SEQ_OPEN;
            idx_q   <= '0;
            pulse_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            case (st_q)
                SEQ_OPEN: begin
                    if (commit_cmd) begin
                        st_q  <= SEQ_BURN;
                        idx_q <= '0;
                    end
                end
                SEQ_BURN: begin
                    if (idx_q == LAST_IDX) begin
                        st_q    <= SEQ_SEALED;
                        pulse_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                SEQ_SEALED: begin
                    if (commit_cmd)
                        err_q <= 1'b1;
                end
                default: st_q <= SEQ_OPEN;
            endcase
        end
    end

    assign busy        = (st_q == SEQ_BURN);
    assign sealed      = (st_q == SEQ_SEALED);
    assign burn_en     = busy;
    assign burn_addr   = idx_q;
    assign reset_pulse = pulse_q;
    assign late_commit = err_q;

endmodule

// File: rtl/otp_commit_ctrl.sv
module otp_commit_ctrl
    import otp_pkg::*;
#(
    parameter int FUSE_BYTES = 256,
    parameter int AW         = $clog2(FUSE_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_priv,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_wdata,
    output logic          rsp_valid,
    output logic          rsp_refused,
    output logic          rsp_not_prog,
    output logic [7:0]    rsp_rdata,
    output logic          busy,
    output logic          stat_unprog,
    output logic          stat_prog,
    output logic          stat_mfg_open,
    output logic          err_locked,
    output logic          acc_lockdown,
    output logic          reset_req,
    output logic [1:0]    sb_state
);

    op_e               op;
    logic              accept;
    logic              sealed;
    logic              burn_en;
    logic [AW-1:0]     burn_addr;
    logic [BYTE_W-1:0] mir_host_q;
    logic [BYTE_W-1:0] mir_burn_q;
    logic [BYTE_W-1:0] fuse_rd;
    logic              verify_en;
    rsp_t              rsp_d, rsp_q;

    assign op     = op_e'(req_op);
    assign accept = req_valid && req_priv && !busy;

    otp_mirror #(.DEPTH(FUSE_BYTES), .AW(AW)) mirror_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (accept && op == OP_STAGE && !sealed),
        .wr_addr   (req_addr),
        .wr_data   (req_wdata),
        .host_addr (req_addr),
        .host_data (mir_host_q),
        .burn_addr (burn_addr),
        .burn_data (mir_burn_q)
    );

    otp_fuse_array #(.DEPTH(FUSE_BYTES), .AW(AW)) fuse_i (
        .clk       (clk),
        .rst       (rst),
        .prog_en   (burn_en),
        .prog_addr (burn_addr),
        .prog_data (mir_burn_q),
        .seal      (sealed),
        .rd_addr   (req_addr),
        .rd_data   (fuse_rd),
        .verify_en (verify_en)
    );

    otp_commit_seq #(.DEPTH(FUSE_BYTES), .AW(AW)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .commit_cmd  (accept && op == OP_COMMIT),
        .busy        (busy),
        .sealed      (sealed),
        .burn_en     (burn_en),
        .burn_addr   (burn_addr),
        .reset_pulse (reset_req),
        .late_commit (err_locked)
    );

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (!accept) begin
                rsp_d.refused = 1'b1;
            end else begin
                case (op)
                    OP_READ_FUSE: begin
                        rsp_d.not_prog = !sealed;
                        rsp_d.data     = sealed ? fuse_rd : '0;
                    end
                    OP_READ_MIRROR: rsp_d.data = mir_host_q;
                    default:        rsp_d.data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rsp_q <= '0;
        else
            rsp_q <= rsp_d;
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_refused   = rsp_q.refused;
    assign rsp_not_prog  = rsp_q.not_prog;
    assign rsp_rdata     = rsp_q.data;
    assign stat_prog     = sealed;
    assign stat_unprog   = !sealed;
    assign stat_mfg_open = !sealed;
    assign acc_lockdown  = sealed;
    assign sb_state      = decode_profile(sealed, verify_en);

endmodule

// File: rtl/otp_commit_ctrl_chk.sv
module otp_commit_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_priv,
    input logic       rsp_valid,
    input logic       rsp_refused,
    input logic       rsp_not_prog,
    input logic [7:0] rsp_rdata,
    input logic       busy,
    input logic       stat_unprog,
    input logic       stat_prog,
    input logic       err_locked,
    input logic       acc_lockdown,
    input logic       reset_req,
    input logic [1:0] sb_state
);

    assert_status_excl_R1: assert property (@(posedge clk) disable iff (rst)
        stat_prog != stat_unprog);

    assert_refuse_unpriv_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_priv |=> rsp_valid && rsp_refused && rsp_rdata == 8'h00);

    assert_blank_read_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_not_prog |-> rsp_rdata == 8'h00 && stat_unprog);

    assert_busy_unsealed_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> stat_unprog && !reset_req);

    assert_pulse_at_seal_R6: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> $rose(stat_prog) && acc_lockdown && $fell(busy));

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);

    assert_seal_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        stat_prog |=> stat_prog && !busy);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_locked |=> err_locked);

    assert_busy_refuse_R9: assert property (@(posedge clk) disable iff (rst)
        req_valid && busy |=> rsp_refused);

    assert_undef_state_R10: assert property (@(posedge clk) disable iff (rst)
        stat_unprog |-> sb_state == 2'd0);

endmodule

bind otp_commit_ctrl otp_commit_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_priv     (req_priv),
    .rsp_valid    (rsp_valid),
    .rsp_refused  (rsp_refused),
    .rsp_not_prog (rsp_not_prog),
    .rsp_rdata    (rsp_rdata),
    .busy         (busy),
    .stat_unprog  (stat_unprog),
    .stat_prog    (stat_prog),
    .err_locked   (err_locked),
    .acc_lockdown (acc_lockdown),
    .reset_req    (reset_req),
    .sb_state     (sb_state)
);

// File: tb/otp_commit_ctrl_tb_top.sv
module otp_commit_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 256;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_priv = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_wdata = '0;
    logic          rsp_valid, rsp_refused, rsp_not_prog;
    logic [7:0]    rsp_rdata;
    logic          busy, stat_unprog, stat_prog, stat_mfg_open;
    logic          err_locked, acc_lockdown, reset_req;
    logic [1:0]    sb_state;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_commit_ctrl #(.FUSE_BYTES(N), .AW(AW)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_priv(req_priv),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_refused(rsp_refused), .rsp_not_prog(rsp_not_prog),
        .rsp_rdata(rsp_rdata), .busy(busy), .stat_unprog(stat_unprog),
        .stat_prog(stat_prog), .stat_mfg_open(stat_mfg_open), .err_locked(err_locked),
        .acc_lockdown(acc_lockdown), .reset_req(reset_req), .sb_state(sb_state)
    );

    function automatic logic [1:0] exp_sb(input logic sealed, input logic [7:0] profile);
        if (!sealed) return 2'd0;
        return profile[0] ? 2'd2 : 2'd1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic send(input logic [1:0] op, input logic priv, input logic [AW-1:0] addr, input logic [7:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_priv = priv; req_op = op; req_addr = addr; req_wdata = data;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h0715_C0DE);
        for (int pass = 0; pass < 2; pass++) begin
            int cnt;
            @(negedge clk); rst = 1'b1;
            repeat (3) @(posedge clk);
            #1;
            check(stat_unprog && !stat_prog && stat_mfg_open && !busy && !err_locked &&
                  !reset_req && !acc_lockdown && sb_state == 2'd0, "R1 reset state",
                  {stat_unprog, stat_prog, stat_mfg_open, busy, err_locked, reset_req, acc_lockdown}, 7'b1010000);
            @(negedge clk); rst = 1'b0;
            @(posedge clk); #1;
            check(stat_unprog && stat_mfg_open && !busy && sb_state == 2'd0, "R1 after release",
                  {stat_unprog, stat_mfg_open, busy}, 3'b110);

            for (int i = 0; i < N; i++) model[i] = 8'($urandom);
            model[32][0] = (pass == 0);

            for (int i = 0; i < N; i++) begin
                send(2'd0, 1'b1, AW'(i), model[i]);
                if ($urandom % 8 == 0) begin
                    send(2'd0, 1'b0, AW'(i), ~model[i]);
                    check(rsp_valid && rsp_refused && rsp_rdata == 8'h00, "R2 unprivileged stage refused",
                          {rsp_valid, rsp_refused}, 2'b11);
                end
            end

            for (int i = 0; i < N; i++) begin
                send(2'd3, 1'b1, AW'(i), 8'h00);
                check(rsp_valid && !rsp_refused && rsp_rdata == model[i], "R3 mirror readback",
                      rsp_rdata, model[i]);
            end

            for (int k = 0; k < 8; k++) begin
                logic [AW-1:0] a;
                a = AW'($urandom);
                send(2'd1, 1'b1, a, 8'h00);
                check(rsp_rdata == 8'h00 && rsp_not_prog, "R4 blank fuse read",
                      {rsp_not_prog, rsp_rdata}, 9'h100);
            end
            check(sb_state == 2'd0, "R10 undefined before seal", sb_state, 2'd0);

            send(2'd2, 1'b0, '0, 8'h00);
            check(rsp_refused && !busy && stat_unprog, "R2 unprivileged commit refused",
                  {rsp_refused, busy, stat_unprog}, 3'b101);

            // privileged commit
            @(negedge clk);
            req_valid = 1'b1; req_priv = 1'b1; req_op = 2'd2; req_addr = '0;
            @(posedge clk); #1;
            req_valid = 1'b0;
            check(busy && !reset_req, "R5 busy rises after commit", {busy, reset_req}, 2'b10);
            cnt = 1;
            @(negedge clk);
            req_valid = 1'b1; req_priv = 1'b1; req_op = 2'd1; req_addr = 8'd0;
            @(posedge clk); #1;
            req_valid = 1'b0;
            check(rsp_valid && rsp_refused && rsp_rdata == 8'h00, "R9 request during burn refused",
                  {rsp_valid, rsp_refused}, 2'b11);
            if (busy) cnt++;
            while (busy && cnt < N + 8) begin
                @(posedge clk); #1;
                if (busy) cnt++;
            end
            check(cnt == N, "R5 burn length", cnt, N);
            check(reset_req && stat_prog && !stat_unprog && !stat_mfg_open && acc_lockdown,
                  "R6 seal status", {reset_req, stat_prog, stat_unprog, stat_mfg_open, acc_lockdown}, 5'b11001);
            @(posedge clk); #1;
            check(!reset_req && stat_prog, "R6 single reset pulse", reset_req, 1'b0);

            for (int i = 0; i < N; i++) begin
                send(2'd1, 1'b1, AW'(i), 8'h00);
                check(rsp_rdata == model[i] && !rsp_not_prog, "R5 R7 fuse contents", rsp_rdata, model[i]);
            end
            check(sb_state == exp_sb(1'b1, model[32]), "R10 profile decode", sb_state, exp_sb(1'b1, model[32]));

            send(2'd0, 1'b1, 8'd5, ~model[5]);
            send(2'd3, 1'b1, 8'd5, 8'h00);
            check(rsp_rdata == model[5], "R7 stage after seal ignored (mirror)", rsp_rdata, model[5]);
            send(2'd1, 1'b1, 8'd5, 8'h00);
            check(rsp_rdata == model[5], "R7 stage after seal ignored (fuse)", rsp_rdata, model[5]);

            check(!err_locked, "R8 no error before late commit", err_locked, 1'b0);
            send(2'd2, 1'b1, '0, 8'h00);
            check(err_locked && !busy && !reset_req, "R8 late commit flagged",
                  {err_locked, busy, reset_req}, 3'b100);
            repeat (3) begin
                @(posedge clk); #1;
                check(!busy && !reset_req && err_locked && stat_prog, "R8 late commit inert",
                      {busy, reset_req, err_locked}, 3'b001);
            end
            send(2'd1, 1'b1, 8'd32, 8'h00);
            check(rsp_rdata == model[32], "R8 fuses unchanged", rsp_rdata, model[32]);
        end
        finish_run();
    end

endmodule